// File: doc/BRIEF.md
# Indirect Byte Register Mailbox Bridge

This block lets a host on a 32-bit memory-mapped bus reach a bank of 8-bit internal registers through one mailbox word, instead of mapping every byte register into the host address space. The host composes a command in the mailbox: a register address, a data byte and a direction bit. A write command commits the byte to the addressed internal register at once. A read command raises a busy flag, fetches the byte over a deliberately slow internal path and then drops busy. The host polls until busy is clear and takes the byte from the top of the mailbox.

Alongside the mailbox, the host side holds a small interrupt unit with seven sources. It has a mask word, a write-one-to-clear word and a sticky status word. The single interrupt line is high while any status bit is both set and unmasked.

The internal bank is a model of a line-protocol controller's register file. It holds two control bytes, two address-match mask bytes, transmit and receive length bytes, a 16-byte transmit buffer, a 16-byte receive buffer and a lock byte. The protocol engines behind these registers are not part of the block.

Top module: `byte_mailbox_bridge`

## Requirements
- R1: After reset the mailbox word, interrupt mask, interrupt status and interrupt line are all zero, and every internal byte register reads 0x00.
- R2: A host write to the mailbox (offset 0x0C) with bit 16 set and busy clear stores bits 15:8 into the internal register addressed by bits 7:0. Busy (bit 23) stays 0 for such a command.
- R3: A host write to the mailbox with bit 16 clear and busy clear starts a read. Busy reads 1 for exactly 4 clock cycles after the accepting edge. The addressed byte then appears in bits 31:24 and stays there until the next read completes.
- R4: Any mailbox write made while busy is 1 is ignored. It leaves the stored command, the internal registers and the pending read result unchanged.
- R5: Internal addresses outside the map read 0x00, and writes to them change nothing. The mapped addresses are 0x00, 0x01, 0x05, 0x06, 0x07, 0x08, 0x10 to 0x2F and 0x30.
- R6: The mailbox reads back the last accepted command: address in bits 7:0, data in bits 15:8 and the write bit in bit 16. Bits 22:17 read 0.
- R7: A pulse on interrupt source i sets status bit i, and the bit stays set. Writing 1 to bit i of the clear word (offset 0x14) clears the bit. If a source pulse and a clear of the same bit fall in the same cycle, the bit ends up set. The clear word reads 0.
- R8: The mask word (offset 0x10) and the status word (offset 0x18) use bits 6:0. The interrupt line is the OR of status AND mask. Host offsets outside the four words read 0.
- R9: The transmit buffer (0x10 to 0x1F) and the receive buffer (0x20 to 0x2F) are 32 independent bytes. Each byte returns the value last written to its own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe for one cycle |
| host_addr | input | 5 | Host byte offset of the word accessed |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr, combinational |
| irq_src | input | 7 | Interrupt source pulses, one bit per source |
| irq_out | output | 1 | Interrupt line, any unmasked status bit set |

## Verification
Two pairs of functions can meet in the same cycle. In the interrupt unit, a source pulse and a host clear of the same status bit can land on the same edge. The bench drives both in one cycle and expects the bit to read back set, with the interrupt line following the mask. In the mailbox, a read can still be in flight when a new command arrives. The bench issues a write command and then a second read in the cycles straight after a read is accepted. It judges the outcome from the returned byte, the stored command fields and a later re-read of the same register, none of which may show the rejected commands.

// File: rtl/mbx_bridge_pkg.sv
// Package: shared offsets, bit positions, command type and address decode
// for the byte mailbox bridge. Assumes internal addresses are 8 bits wide.
package mbx_bridge_pkg;

    localparam int HOST_AW = 5;

    // Host-side word offsets
    localparam logic [HOST_AW-1:0] OFS_MBX   = 5'h0C;
    localparam logic [HOST_AW-1:0] OFS_IMASK = 5'h10;
    localparam logic [HOST_AW-1:0] OFS_ICLR  = 5'h14;
    localparam logic [HOST_AW-1:0] OFS_ISTAT = 5'h18;

    // Mailbox bit positions
    localparam int MBX_WR_BIT   = 16;
    localparam int MBX_BUSY_BIT = 23;

    // Internal byte register addresses
    localparam logic [7:0] IA_CTRL_MAIN = 8'h00;
    localparam logic [7:0] IA_CTRL_AUX  = 8'h01;
    localparam logic [7:0] IA_MATCH_LO  = 8'h05;
    localparam logic [7:0] IA_MATCH_HI  = 8'h06;
    localparam logic [7:0] IA_TX_LEN    = 8'h07;
    localparam logic [7:0] IA_RX_LEN    = 8'h08;
    localparam logic [7:0] IA_TX_BASE   = 8'h10;
    localparam logic [7:0] IA_RX_BASE   = 8'h20;
    localparam logic [7:0] IA_RX_HOLD   = 8'h30;

    typedef struct packed {
        logic       wr;
        logic [7:0] data;
        logic [7:0] addr;
    } mbx_cmd_t;

    // True when the internal address selects a real byte register
    function automatic logic ia_is_mapped(input logic [7:0] a, input int depth);
        logic hit;
        hit = (a == IA_CTRL_MAIN) || (a == IA_CTRL_AUX) || (a == IA_MATCH_LO) ||
              (a == IA_MATCH_HI)  || (a == IA_TX_LEN)   || (a == IA_RX_LEN)   ||
              (a == IA_RX_HOLD);
        if (a >= IA_TX_BASE && int'(a) < int'(IA_TX_BASE) + depth) hit = 1'b1;
        if (a >= IA_RX_BASE && int'(a) < int'(IA_RX_BASE) + depth) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/mbx_cmd_ctrl.sv
// Module: mbx_cmd_ctrl
// Accepts mailbox commands, performs byte writes at once and runs reads
// through a fixed-latency busy window. Assumes RD_LAT >= 1 and that the
// bank read data is valid combinationally for bank_raddr.
module mbx_cmd_ctrl
    import mbx_bridge_pkg::*;
#(
    parameter int RD_LAT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  mbx_cmd_t    cmd_in,
    input  logic [7:0]  bank_rdata,
    output logic        bank_we,
    output logic [7:0]  bank_waddr,
    output logic [7:0]  bank_wdata,
    output logic [7:0]  bank_raddr,
    output logic [31:0] mbx_word
);

    localparam int CNT_W = $clog2(RD_LAT + 1);

    mbx_cmd_t       cmd_q;
    logic           busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]     rdata_q;
    logic           accept;

    // A command is taken only while no read is in flight
    assign accept = cmd_valid && !busy_q;

    // Byte write path goes straight to the bank on acceptance
    assign bank_we    = accept && cmd_in.wr;
    assign bank_waddr = cmd_in.addr;
    assign bank_wdata = cmd_in.data;
    assign bank_raddr = cmd_q.addr;

    // Store the accepted command fields for readback and for the read address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_in;
        end
    end

    // Busy window and latency countdown for read commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept && !cmd_in.wr) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(RD_LAT);
        end else if (busy_q) begin
            if (cnt_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // Capture the fetched byte on the last cycle of the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (busy_q && cnt_q == CNT_W'(1)) begin
            rdata_q <= bank_rdata;
        end
    end

    // Pack the mailbox word seen by the host
    always_comb begin
        mbx_word = '0;
        mbx_word[7:0]          = cmd_q.addr;
        mbx_word[15:8]         = cmd_q.data;
        mbx_word[MBX_WR_BIT]   = cmd_q.wr;
        mbx_word[MBX_BUSY_BIT] = busy_q;
        mbx_word[31:24]        = rdata_q;
    end

    // R4: a command arriving during a read leaves the stored command alone
    a_r4_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cmd_valid) |=> $stable(cmd_q));

    // R3: the countdown stays inside the configured window while busy
    a_r3_window_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q >= CNT_W'(1) && cnt_q <= CNT_W'(RD_LAT)));

    // R3: the read result only moves on the cycle busy falls
    a_r3_result_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_q) |-> ($past(busy_q) && !busy_q));

    // R2: an accepted write command never raises busy
    a_r2_write_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_in.wr) |=> !busy_q);

endmodule

// File: rtl/byte_reg_bank.sv
// Module: byte_reg_bank
// Model of the internal 8-bit register file: control, match masks, lengths,
// transmit and receive buffers and a hold byte. Unmapped addresses read 0
// and drop writes. Assumes 2 <= BUF_DEPTH <= 16 so buffers stay in their
// 16-byte windows.
module byte_reg_bank
    import mbx_bridge_pkg::*;
#(
    parameter int BUF_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] waddr,
    input  logic [7:0] wdata,
    input  logic [7:0] raddr,
    output logic [7:0] rdata
);

    localparam int IDX_W = $clog2(BUF_DEPTH);
    localparam logic [7:0] TX_END = IA_TX_BASE + 8'(BUF_DEPTH);
    localparam logic [7:0] RX_END = IA_RX_BASE + 8'(BUF_DEPTH);

    logic [7:0] ctrl_main_q, ctrl_aux_q, match_lo_q, match_hi_q;
    logic [7:0] tx_len_q, rx_len_q, rx_hold_q;
    logic [8*BUF_DEPTH-1:0] tx_flat, rx_flat;
    logic [IDX_W-1:0] ridx;

    // Single-byte registers written by address match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_main_q <= '0;
            ctrl_aux_q  <= '0;
            match_lo_q  <= '0;
            match_hi_q  <= '0;
            tx_len_q    <= '0;
            rx_len_q    <= '0;
            rx_hold_q   <= '0;
        end else if (we) begin
            case (waddr)
                IA_CTRL_MAIN: ctrl_main_q <= wdata;
                IA_CTRL_AUX:  ctrl_aux_q  <= wdata;
                IA_MATCH_LO:  match_lo_q  <= wdata;
                IA_MATCH_HI:  match_hi_q  <= wdata;
                IA_TX_LEN:    tx_len_q    <= wdata;
                IA_RX_LEN:    rx_len_q    <= wdata;
                IA_RX_HOLD:   rx_hold_q   <= wdata;
                default: ;
            endcase
        end
    end

    // One byte cell per buffer slot, transmit and receive
    for (genvar i = 0; i < BUF_DEPTH; i++) begin : g_buf
        logic [7:0] tx_byte_q, rx_byte_q;

        // Transmit slot i holds the last byte written to its address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tx_byte_q <= '0;
            end else if (we && waddr == IA_TX_BASE + 8'(i)) begin
                tx_byte_q <= wdata;
            end
        end

        // Receive slot i holds the last byte written to its address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rx_byte_q <= '0;
            end else if (we && waddr == IA_RX_BASE + 8'(i)) begin
                rx_byte_q <= wdata;
            end
        end

        assign tx_flat[8*i +: 8] = tx_byte_q;
        assign rx_flat[8*i +: 8] = rx_byte_q;
    end

    assign ridx = raddr[IDX_W-1:0];

    // Read multiplexer, zero for anything outside the map
    always_comb begin
        rdata = '0;
        case (raddr)
            IA_CTRL_MAIN: rdata = ctrl_main_q;
            IA_CTRL_AUX:  rdata = ctrl_aux_q;
            IA_MATCH_LO:  rdata = match_lo_q;
            IA_MATCH_HI:  rdata = match_hi_q;
            IA_TX_LEN:    rdata = tx_len_q;
            IA_RX_LEN:    rdata = rx_len_q;
            IA_RX_HOLD:   rdata = rx_hold_q;
            default: begin
                if (raddr >= IA_TX_BASE && raddr < TX_END) begin
                    rdata = tx_flat[{ridx, 3'b000} +: 8];
                end else if (raddr >= IA_RX_BASE && raddr < RX_END) begin
                    rdata = rx_flat[{ridx, 3'b000} +: 8];
                end
            end
        endcase
    end

    // R5: a write to an unmapped address leaves every register unchanged
    a_r5_unmapped_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !ia_is_mapped(waddr, BUF_DEPTH)) |=>
        $stable({ctrl_main_q, ctrl_aux_q, match_lo_q, match_hi_q,
                 tx_len_q, rx_len_q, rx_hold_q, tx_flat, rx_flat}));

    // R9: a write to one transmit slot never disturbs the receive buffer
    a_r9_tx_write_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr >= IA_TX_BASE && waddr < TX_END) |=> $stable(rx_flat));

endmodule

// File: rtl/irq_unit.sv
// Module: irq_unit
// Sticky interrupt status with a mask and a write-one-to-clear port.
// A source pulse wins over a clear of the same bit in the same cycle.
module irq_unit #(
    parameter int N_SRC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] wbits,
    output logic [N_SRC-1:0] mask_q,
    output logic [N_SRC-1:0] status_q,
    output logic             irq
);

    logic [N_SRC-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;

    // Mask register written whole by the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wbits;
        end
    end

    // Status bits: set by sources, cleared by host, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_bits) | src;
        end
    end

    // Interrupt line from unmasked pending bits
    assign irq = |(status_q & mask_q);

    // R7: every source pulse is recorded even under a simultaneous clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|src) |=> ((status_q & $past(src)) == $past(src)));

    // R7: a cleared bit without a fresh pulse reads back zero
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((wbits & src) == '0)) |=> ((status_q & $past(wbits)) == '0));

endmodule

// File: rtl/byte_mailbox_bridge.sv
// Module: byte_mailbox_bridge
// Top: decodes the host word offsets, forwards mailbox writes to the
// command controller, and hosts the interrupt unit. Host reads are
// combinational on host_addr; writes take effect on the strobed edge.
module byte_mailbox_bridge
    import mbx_bridge_pkg::*;
#(
    parameter int RD_LAT    = 4,
    parameter int BUF_DEPTH = 16,
    parameter int N_SRC     = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic [N_SRC-1:0]   irq_src,
    output logic               irq_out
);

    mbx_cmd_t         cmd;
    logic             bank_we;
    logic [7:0]       bank_waddr, bank_wdata, bank_raddr, bank_rdata;
    logic [31:0]      mbx_word;
    logic [N_SRC-1:0] imask, istat;
    logic             unused_wbits;

    assign unused_wbits = ^host_wdata[31:MBX_WR_BIT+1];

    // Split the host write into command fields
    assign cmd.addr = host_wdata[7:0];
    assign cmd.data = host_wdata[15:8];
    assign cmd.wr   = host_wdata[MBX_WR_BIT];

    mbx_cmd_ctrl #(
        .RD_LAT(RD_LAT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (host_we && host_addr == OFS_MBX),
        .cmd_in     (cmd),
        .bank_rdata (bank_rdata),
        .bank_we    (bank_we),
        .bank_waddr (bank_waddr),
        .bank_wdata (bank_wdata),
        .bank_raddr (bank_raddr),
        .mbx_word   (mbx_word)
    );

    byte_reg_bank #(
        .BUF_DEPTH(BUF_DEPTH)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .waddr (bank_waddr),
        .wdata (bank_wdata),
        .raddr (bank_raddr),
        .rdata (bank_rdata)
    );

    irq_unit #(
        .N_SRC(N_SRC)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (irq_src),
        .mask_we  (host_we && host_addr == OFS_IMASK),
        .clr_we   (host_we && host_addr == OFS_ICLR),
        .wbits    (host_wdata[N_SRC-1:0]),
        .mask_q   (imask),
        .status_q (istat),
        .irq      (irq_out)
    );

    // Host read multiplexer; clear word and unknown offsets read zero
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_MBX:   host_rdata = mbx_word;
            OFS_IMASK: host_rdata[N_SRC-1:0] = imask;
            OFS_ISTAT: host_rdata[N_SRC-1:0] = istat;
            default: ;
        endcase
    end

    // R8: the line never rises without a pending unmasked source
    a_r8_line_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> ((istat & imask) != '0));

endmodule

// File: tb/byte_mailbox_bridge_tb_top.sv
// Directed bench for byte_mailbox_bridge: one task per scenario.
module byte_mailbox_bridge_tb_top;

    localparam logic [4:0] H_MBX = 5'h0C, H_MASK = 5'h10, H_CLR = 5'h14, H_STAT = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [6:0]  irq_src = '0;
    logic        irq_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    byte_mailbox_bridge dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq_src    (irq_src),
        .irq_out    (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [4:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic byte_wr(input logic [7:0] a, input logic [7:0] d);
        host_wr(H_MBX, {15'd0, 1'b1, d, a});
    endtask

    // Issue a read command and count the cycles busy stays high
    task automatic byte_rd(input logic [7:0] a, output logic [7:0] d, output int lat);
        logic [31:0] w;
        host_wr(H_MBX, {16'd0, 8'h00, a});
        lat = 0;
        host_rd(H_MBX, w);
        while (w[23] && lat < 20) begin
            lat++;
            @(negedge clk);
            host_rd(H_MBX, w);
        end
        d = w[31:24];
    endtask

    task automatic t_reset();
        logic [31:0] w; logic [7:0] b; int lat;
        host_rd(H_MBX, w);  chk("R1 mailbox", w, 32'h0);
        host_rd(H_MASK, w); chk("R1 mask", w, 32'h0);
        host_rd(H_STAT, w); chk("R1 status", w, 32'h0);
        chk("R1 irq", {31'd0, irq_out}, 32'h0);
        byte_rd(8'h30, b, lat); chk("R1 hold byte", {24'd0, b}, 32'h0);
    endtask

    task automatic t_write_read();
        logic [31:0] w; logic [7:0] b; int lat;
        byte_wr(8'h00, 8'h5A);
        host_rd(H_MBX, w); chk("R2 no busy on write", {31'd0, w[23]}, 32'h0);
        byte_wr(8'h07, 8'h3C);
        byte_wr(8'h06, 8'h80);
        byte_rd(8'h00, b, lat);
        chk("R2 ctrl byte", {24'd0, b}, 32'h5A);
        chk("R3 busy cycles", lat, 4);
        byte_rd(8'h07, b, lat); chk("R2 tx length", {24'd0, b}, 32'h3C);
        byte_rd(8'h06, b, lat); chk("R2 match hi", {24'd0, b}, 32'h80);
        repeat (3) @(negedge clk);
        host_rd(H_MBX, w); chk("R3 result held", {24'd0, w[31:24]}, 32'h80);
    endtask

    task automatic t_fields();
        logic [31:0] w;
        byte_wr(8'h07, 8'hC3);
        host_rd(H_MBX, w);
        chk("R6 command fields", {8'd0, w[23:0]}, 32'h0001C307);
    endtask

    task automatic t_buffers();
        logic [7:0] b; int lat; int bad = 0;
        for (int i = 0; i < 16; i++) byte_wr(8'(8'h10 + i), 8'(8'hA0 + i));
        for (int i = 0; i < 16; i++) byte_wr(8'(8'h20 + i), 8'(8'h50 + 3 * i));
        for (int i = 0; i < 16; i++) begin
            byte_rd(8'(8'h10 + i), b, lat);
            if (b !== 8'(8'hA0 + i)) bad++;
            byte_rd(8'(8'h20 + i), b, lat);
            if (b !== 8'(8'h50 + 3 * i)) bad++;
        end
        chk("R9 buffer slots mismatched", bad, 0);
        byte_rd(8'h1F, b, lat); chk("R9 last tx slot", {24'd0, b}, 32'hAF);
    endtask

    task automatic t_unmapped();
        logic [7:0] b; int lat;
        byte_wr(8'h02, 8'h77);
        byte_wr(8'h31, 8'h77);
        byte_wr(8'hFF, 8'h77);
        byte_rd(8'h02, b, lat); chk("R5 addr 0x02", {24'd0, b}, 32'h0);
        byte_rd(8'h31, b, lat); chk("R5 addr 0x31", {24'd0, b}, 32'h0);
        byte_rd(8'hFF, b, lat); chk("R5 addr 0xFF", {24'd0, b}, 32'h0);
        byte_wr(8'h30, 8'h01);
        byte_rd(8'h30, b, lat); chk("R5 hold byte mapped", {24'd0, b}, 32'h01);
        byte_rd(8'h10, b, lat); chk("R5 neighbour untouched", {24'd0, b}, 32'hA0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] w; logic [7:0] b; int lat;
        @(negedge clk);
        host_we = 1'b1; host_addr = H_MBX; host_wdata = 32'h0000_0000;
        @(negedge clk);
        host_wdata = 32'h0001_1100;
        @(negedge clk);
        host_wdata = 32'h0000_0007;
        @(negedge clk);
        host_we = 1'b0;
        host_rd(H_MBX, w);
        chk("R4 stored command", {8'd0, w[23:0]}, 32'h0080_0000);
        lat = 0;
        while (w[23] && lat < 20) begin
            lat++;
            @(negedge clk);
            host_rd(H_MBX, w);
        end
        chk("R4 read result", {24'd0, w[31:24]}, 32'h5A);
        byte_rd(8'h00, b, lat); chk("R4 write dropped", {24'd0, b}, 32'h5A);
    endtask

    task automatic t_irq();
        logic [31:0] w;
        host_wr(H_MASK, 32'h05);
        host_rd(H_MASK, w); chk("R8 mask readback", w, 32'h05);
        @(negedge clk); irq_src = 7'h01;
        @(negedge clk); irq_src = 7'h00;
        host_rd(H_STAT, w); chk("R7 status set", w, 32'h01);
        chk("R8 irq high", {31'd0, irq_out}, 32'h1);
        @(negedge clk); irq_src = 7'h02;
        @(negedge clk); irq_src = 7'h00;
        repeat (2) @(negedge clk);
        host_rd(H_STAT, w); chk("R7 sticky", w, 32'h03);
        host_wr(H_CLR, 32'h01);
        host_rd(H_STAT, w); chk("R7 cleared", w, 32'h02);
        chk("R8 irq masked off", {31'd0, irq_out}, 32'h0);
        host_rd(H_CLR, w); chk("R7 clear reads zero", w, 32'h0);
        host_rd(5'h04, w); chk("R8 unknown offset", w, 32'h0);
        @(negedge clk);
        irq_src = 7'h04; host_we = 1'b1; host_addr = H_CLR; host_wdata = 32'h06;
        @(negedge clk);
        irq_src = 7'h00; host_we = 1'b0;
        host_rd(H_STAT, w); chk("R7 set beats clear", w, 32'h04);
        chk("R8 irq from bit 2", {31'd0, irq_out}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_fields();
        t_buffers();
        t_unmapped();
        t_busy_ignore();
        t_irq();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule